// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block is the finite-state controller that chooses the chip's power mode among normal run, wait, stop, low-power run and low-power wait. It drives three controls from the current mode: a regulator-mode select (full or loose regulation), the system bus clock enable and the active signal of the low-voltage detector. Low-power run and low-power wait are ordinary run and wait with the regulator held in loose regulation. The bus clock keeps running, so every peripheral stays clocked at the reduced frequency.

The CPU posts a mode request as a one-cycle valid pulse with a code. A request for a low-power mode is accepted only when three conditions hold. The clock source must be the external clock or the crystal oscillator. The CPU clock must not exceed a frequency limit. The voltage detector must be either disabled or not set to stay on in stop. A refused request leaves the mode unchanged and raises a sticky error flag. While a low-power mode is active the detector is suspended. Returning to normal run first asks for full regulation and waits for a regulator-ready handshake. Only then does it report normal run and bring the detector back. If the clock conditions are lost during a low-power mode, the block forces that same exit.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is normal run (code 0), the regulator select is full (0), the bus clock enable is 1, the error flag is 0 and the detector active signal equals the detector enable input.
- R2: Request codes are 0 run, 1 wait, 2 stop, 3 low-power run, 4 low-power wait. The mode output uses the same codes plus 5 for exiting to run. In normal run a valid wait or stop request enters that mode at the next clock edge.
- R3: Wait keeps full regulation and the bus clock running, and a wake event returns it to normal run. Stop clears the bus clock enable and selects loose regulation, and a wake event moves it to the exiting state.
- R4: In low-power run and low-power wait the regulator select is loose (1) and the bus clock enable stays 1.
- R5: A low-power request is accepted only when the clock source code is 1 (external clock) or 2 (crystal oscillator). Codes 0 and 3 (internal sources) refuse it.
- R6: A low-power request is accepted only when the CPU clock indication, in kHz, is at most LP_FREQ_MAX_KHZ (default 250).
- R7: A low-power request is accepted only when the detector enable is 0 or its stop-enable is 0.
- R8: A refused low-power request leaves the mode unchanged and sets the error flag. The flag holds until an error-clear pulse, and a refusal in the same cycle as a clear leaves it set.
- R9: The detector active signal is 0 in low-power run, low-power wait and the exiting state. It follows the detector enable in run and wait, and equals enable AND stop-enable in stop.
- R10: A run request in low-power run enters the exiting state with full regulation and the detector still off. The state holds while regulator-ready is 0 and becomes normal run one edge after regulator-ready is 1.
- R11: In low-power run a low-power wait request enters low-power wait and a stop request enters stop. A wake event in low-power wait returns to low-power run.
- R12: In either low-power mode, losing the clock-source or frequency condition forces the exiting state at the next edge, ahead of any wake event or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Mode request strobe from the CPU |
| req_code_i | input | 3 | Requested mode code |
| clk_src_i | input | 2 | Active clock source code |
| cpu_freq_khz_i | input | FREQ_W | Current CPU clock frequency in kHz |
| lvd_en_i | input | 1 | Low-voltage detector enable setting |
| lvd_stop_en_i | input | 1 | Detector stays-on-in-stop setting |
| wake_i | input | 1 | Interrupt or wake event |
| reg_ready_i | input | 1 | Regulator reports full regulation reached |
| err_clr_i | input | 1 | Clears the sticky refusal flag |
| mode_o | output | 3 | Current mode code |
| reg_loose_o | output | 1 | 1 selects loose regulation |
| bus_clk_en_o | output | 1 | System bus clock enable |
| lvd_active_o | output | 1 | Detector active |
| lp_err_o | output | 1 | Sticky refused-request flag |

## Verification
The bench builds the controller with FREQ_W = 10 and the default 250 kHz limit. With these values every frequency from 0 to 1023 is requested in turn, so the accept boundary at 250/251 and the whole refusal range are covered. The clock-source codes and both detector bits are then swept across the boundary frequencies for both low-power request codes. Each accepted entry is followed by its exit path, including a wait on the regulator handshake. Directed sequences cover stop, wait, forced exit taking priority over wake, and the clear-versus-refusal race on the error flag.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        M_RUN    = 3'd0,
        M_WAIT   = 3'd1,
        M_STOP   = 3'd2,
        M_LPRUN  = 3'd3,
        M_LPWAIT = 3'd4,
        M_EXIT   = 3'd5
    } mode_e;

    localparam logic [2:0] REQ_RUN    = 3'd0;
    localparam logic [2:0] REQ_WAIT   = 3'd1;
    localparam logic [2:0] REQ_STOP   = 3'd2;
    localparam logic [2:0] REQ_LPRUN  = 3'd3;
    localparam logic [2:0] REQ_LPWAIT = 3'd4;

    localparam logic [1:0] CSRC_INT      = 2'd0;
    localparam logic [1:0] CSRC_EXT      = 2'd1;
    localparam logic [1:0] CSRC_XTAL     = 2'd2;
    localparam logic [1:0] CSRC_INT_FAST = 2'd3;

    typedef struct packed {
        mode_e mode;
        logic  err;
    } ctrl_state_t;

endpackage

// File: rtl/pwr_entry_qual.sv
module pwr_entry_qual
    import pwr_mode_pkg::*;
#(
    parameter int FREQ_W          = 16,
    parameter int LP_FREQ_MAX_KHZ = 250
) (
    input  logic [1:0]        clk_src_i,
    input  logic [FREQ_W-1:0] cpu_freq_khz_i,
    input  logic              lvd_en_i,
    input  logic              lvd_stop_en_i,
    output logic              clk_ok_o,
    output logic              entry_ok_o
);
    localparam logic [FREQ_W-1:0] FREQ_LIMIT = FREQ_W'(LP_FREQ_MAX_KHZ);

    logic src_ok;
    logic freq_ok;
    logic lvd_ok;

    always_comb begin
        // Only sources that do not depend on the full-regulation current reference
        src_ok     = (clk_src_i == CSRC_EXT) || (clk_src_i == CSRC_XTAL);
        freq_ok    = (cpu_freq_khz_i <= FREQ_LIMIT);
        // Detector may run only if it can be suspended (not kept on in stop)
        lvd_ok     = !lvd_en_i || !lvd_stop_en_i;
        clk_ok_o   = src_ok && freq_ok;
        entry_ok_o = clk_ok_o && lvd_ok;
    end
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
    import pwr_mode_pkg::*;
(
    input  mode_e mode_i,
    input  logic  lvd_en_i,
    input  logic  lvd_stop_en_i,
    output logic  reg_loose_o,
    output logic  bus_clk_en_o,
    output logic  lvd_active_o
);
    always_comb begin
        reg_loose_o  = 1'b0;
        bus_clk_en_o = 1'b1;
        lvd_active_o = 1'b0;
        unique case (mode_i)
            M_RUN, M_WAIT: begin
                lvd_active_o = lvd_en_i;
            end
            M_STOP: begin
                reg_loose_o  = 1'b1;
                bus_clk_en_o = 1'b0;
                lvd_active_o = lvd_en_i && lvd_stop_en_i;
            end
            M_LPRUN, M_LPWAIT: begin
                reg_loose_o  = 1'b1;
            end
            M_EXIT: begin
                // Full regulation requested; detector waits for ready
                reg_loose_o  = 1'b0;
            end
            default: begin
                reg_loose_o  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int FREQ_W          = 16,
    parameter int LP_FREQ_MAX_KHZ = 250
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [2:0]        req_code_i,
    input  logic [1:0]        clk_src_i,
    input  logic [FREQ_W-1:0] cpu_freq_khz_i,
    input  logic              lvd_en_i,
    input  logic              lvd_stop_en_i,
    input  logic              wake_i,
    input  logic              reg_ready_i,
    input  logic              err_clr_i,
    output logic [2:0]        mode_o,
    output logic              reg_loose_o,
    output logic              bus_clk_en_o,
    output logic              lvd_active_o,
    output logic              lp_err_o
);
    ctrl_state_t st_d, st_q;
    logic        clk_ok;
    logic        entry_ok;
    logic        refuse;

    pwr_entry_qual #(
        .FREQ_W          (FREQ_W),
        .LP_FREQ_MAX_KHZ (LP_FREQ_MAX_KHZ)
    ) u_qual (
        .clk_src_i      (clk_src_i),
        .cpu_freq_khz_i (cpu_freq_khz_i),
        .lvd_en_i       (lvd_en_i),
        .lvd_stop_en_i  (lvd_stop_en_i),
        .clk_ok_o       (clk_ok),
        .entry_ok_o     (entry_ok)
    );

    always_comb begin
        st_d   = st_q;
        refuse = 1'b0;
        unique case (st_q.mode)
            M_RUN: begin
                if (req_valid_i) begin
                    case (req_code_i)
                        REQ_WAIT:  st_d.mode = M_WAIT;
                        REQ_STOP:  st_d.mode = M_STOP;
                        REQ_LPRUN: begin
                            if (entry_ok) st_d.mode = M_LPRUN;
                            else          refuse    = 1'b1;
                        end
                        REQ_LPWAIT: begin
                            if (entry_ok) st_d.mode = M_LPWAIT;
                            else          refuse    = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            M_WAIT: begin
                if (wake_i) st_d.mode = M_RUN;
            end
            M_STOP: begin
                if (wake_i) st_d.mode = M_EXIT;
            end
            M_LPRUN: begin
                if (!clk_ok) begin
                    st_d.mode = M_EXIT;
                end else if (req_valid_i) begin
                    case (req_code_i)
                        REQ_RUN:    st_d.mode = M_EXIT;
                        REQ_LPWAIT: st_d.mode = M_LPWAIT;
                        REQ_STOP:   st_d.mode = M_STOP;
                        default: ;
                    endcase
                end
            end
            M_LPWAIT: begin
                if (!clk_ok)     st_d.mode = M_EXIT;
                else if (wake_i) st_d.mode = M_LPRUN;
            end
            M_EXIT: begin
                if (reg_ready_i) st_d.mode = M_RUN;
            end
            default: st_d.mode = M_RUN;
        endcase

        if (refuse)         st_d.err = 1'b1;
        else if (err_clr_i) st_d.err = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mode <= M_RUN;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    pwr_out_decode u_dec (
        .mode_i        (st_q.mode),
        .lvd_en_i      (lvd_en_i),
        .lvd_stop_en_i (lvd_stop_en_i),
        .reg_loose_o   (reg_loose_o),
        .bus_clk_en_o  (bus_clk_en_o),
        .lvd_active_o  (lvd_active_o)
    );

    assign mode_o   = st_q.mode;
    assign lp_err_o = st_q.err;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
    parameter int FREQ_W          = 16,
    parameter int LP_FREQ_MAX_KHZ = 250
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic [2:0]        req_code_i,
    input logic [1:0]        clk_src_i,
    input logic [FREQ_W-1:0] cpu_freq_khz_i,
    input logic              lvd_en_i,
    input logic              lvd_stop_en_i,
    input logic              wake_i,
    input logic              reg_ready_i,
    input logic              err_clr_i,
    input logic [2:0]        mode_o,
    input logic              reg_loose_o,
    input logic              bus_clk_en_o,
    input logic              lvd_active_o,
    input logic              lp_err_o
);
    logic clk_cond;
    logic lvd_cond;
    logic lp_mode;
    logic lp_req;

    always_comb begin
        clk_cond = ((clk_src_i == 2'd1) || (clk_src_i == 2'd2))
                   && (cpu_freq_khz_i <= FREQ_W'(LP_FREQ_MAX_KHZ));
        lvd_cond = !(lvd_en_i && lvd_stop_en_i);
        lp_mode  = (mode_o == 3'd3) || (mode_o == 3'd4);
        lp_req   = req_valid_i && ((req_code_i == 3'd3) || (req_code_i == 3'd4));
    end

    assert_stop_gates_clock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd2) |-> (!bus_clk_en_o && reg_loose_o));

    assert_lp_loose_clocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lp_mode |-> (reg_loose_o && bus_clk_en_o));

    assert_refuse_holds_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode_o == 3'd0) && lp_req && !(clk_cond && lvd_cond)) |=> ((mode_o == 3'd0) && lp_err_o));

    assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lp_err_o && !err_clr_i) |=> lp_err_o);

    assert_lvd_suspended_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lp_mode || (mode_o == 3'd5)) |-> !lvd_active_o);

    assert_exit_waits_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode_o == 3'd5) && !reg_ready_i) |=> (mode_o == 3'd5));

    assert_forced_exit_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lp_mode && !clk_cond) |=> (mode_o == 3'd5));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
    .FREQ_W          (FREQ_W),
    .LP_FREQ_MAX_KHZ (LP_FREQ_MAX_KHZ)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_code_i     (req_code_i),
    .clk_src_i      (clk_src_i),
    .cpu_freq_khz_i (cpu_freq_khz_i),
    .lvd_en_i       (lvd_en_i),
    .lvd_stop_en_i  (lvd_stop_en_i),
    .wake_i         (wake_i),
    .reg_ready_i    (reg_ready_i),
    .err_clr_i      (err_clr_i),
    .mode_o         (mode_o),
    .reg_loose_o    (reg_loose_o),
    .bus_clk_en_o   (bus_clk_en_o),
    .lvd_active_o   (lvd_active_o),
    .lp_err_o       (lp_err_o)
);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
    localparam int FW   = 10;
    localparam int FMAX = 250;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_code = 3'd0;
    logic [1:0]    clk_src = 2'd1;
    logic [FW-1:0] freq = '0;
    logic          lvd_en = 1'b1;
    logic          lvd_se = 1'b0;
    logic          wake = 1'b0;
    logic          ready = 1'b0;
    logic          err_clr = 1'b0;
    logic [2:0]    mode;
    logic          loose, busclk, lvd_act, err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.FREQ_W(FW), .LP_FREQ_MAX_KHZ(FMAX)) u_pwr_mode_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_code_i(req_code),
        .clk_src_i(clk_src), .cpu_freq_khz_i(freq), .lvd_en_i(lvd_en),
        .lvd_stop_en_i(lvd_se), .wake_i(wake), .reg_ready_i(ready), .err_clr_i(err_clr),
        .mode_o(mode), .reg_loose_o(loose), .bus_clk_en_o(busclk),
        .lvd_active_o(lvd_act), .lp_err_o(err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic request(input logic [2:0] code);
        req_valid = 1'b1;
        req_code  = code;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        tick();
        wake = 1'b0;
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        tick();
        err_clr = 1'b0;
    endtask

    // From low-power run: request run, wait on the regulator, back to run
    task automatic leave_lp(input string tag);
        request(3'd0);
        check({tag, " R10 exit state"}, mode, 5);
        check({tag, " R10 full regulation"}, loose, 0);
        check({tag, " R9 detector off in exit"}, lvd_act, 0);
        tick();
        check({tag, " R10 holds without ready"}, mode, 5);
        ready = 1'b1;
        tick();
        ready = 1'b0;
        check({tag, " R10 back to run"}, mode, 0);
        check({tag, " R10 detector restored"}, lvd_act, int'(lvd_en));
    endtask

    initial begin
        repeat (3) tick();
        check("R1 reset mode", mode, 0);
        check("R1 reset regulator", loose, 0);
        check("R1 reset bus clock", busclk, 1);
        check("R1 reset detector", lvd_act, 1);
        check("R1 reset error", err, 0);
        rst_n = 1'b1;
        tick();

        // Cross sweep of source, detector bits and boundary frequencies
        for (int c = 3; c <= 4; c++) begin
            for (int s = 0; s < 4; s++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int t = 0; t < 2; t++) begin
                        for (int fi = 0; fi < 4; fi++) begin
                            int  fv;
                            bit  s_ok, f_ok, l_ok, ok;
                            string tag;
                            fv = (fi == 0) ? 0 : (fi == 1) ? FMAX : (fi == 2) ? FMAX + 1 : 1023;
                            clk_src = 2'(s); lvd_en = 1'(e); lvd_se = 1'(t); freq = FW'(fv);
                            clear_err();
                            s_ok = (s == 1) || (s == 2);
                            f_ok = (fv <= FMAX);
                            l_ok = (e == 0) || (t == 0);
                            ok   = s_ok && f_ok && l_ok;
                            tag  = !s_ok ? "R5" : !f_ok ? "R6" : !l_ok ? "R7" : "R4";
                            request(3'(c));
                            check({tag, " entry decision"}, mode, ok ? c : 0);
                            check("R8 error on refusal", err, ok ? 0 : 1);
                            if (ok) begin
                                check("R4 loose regulation", loose, 1);
                                check("R4 bus clock kept", busclk, 1);
                                check("R9 detector suspended", lvd_act, 0);
                                if (c == 4) begin
                                    pulse_wake();
                                    check("R11 wake to lp run", mode, 3);
                                end
                                leave_lp("sweep");
                            end
                        end
                    end
                end
            end
        end

        // Whole frequency range, good source, detector off
        clk_src = 2'd2; lvd_en = 1'b0; lvd_se = 1'b1;
        for (int f = 0; f < 1024; f++) begin
            freq = FW'(f);
            clear_err();
            request(3'd3);
            check("R6 frequency limit", mode, (f <= FMAX) ? 3 : 0);
            if (f <= FMAX) begin
                request(3'd0);
                ready = 1'b1;
                tick();
                ready = 1'b0;
                check("R10 return", mode, 0);
            end
        end

        // Wait and stop
        freq = FW'(100); clk_src = 2'd1; lvd_en = 1'b1; lvd_se = 1'b1;
        request(3'd1);
        check("R2 enter wait", mode, 1);
        check("R3 wait bus clock", busclk, 1);
        check("R3 wait regulation", loose, 0);
        check("R9 detector in wait", lvd_act, 1);
        pulse_wake();
        check("R3 wake from wait", mode, 0);
        request(3'd2);
        check("R2 enter stop", mode, 2);
        check("R3 stop bus clock off", busclk, 0);
        check("R3 stop loose", loose, 1);
        check("R9 detector in stop follows stop-enable", lvd_act, 1);
        lvd_se = 1'b0;
        #1 check("R9 detector in stop off", lvd_act, 0);
        pulse_wake();
        check("R3 stop wake to exit", mode, 5);
        ready = 1'b1; tick(); ready = 1'b0;
        check("R3 stop exit done", mode, 0);

        // Low-power run to stop and to wait
        request(3'd3);
        check("R11 lp run entered", mode, 3);
        request(3'd4);
        check("R11 lp run to lp wait", mode, 4);
        pulse_wake();
        check("R11 lp wait wake", mode, 3);
        request(3'd1);
        check("R11 wait request ignored in lp run", mode, 3);
        request(3'd2);
        check("R11 lp run to stop", mode, 2);
        pulse_wake();
        ready = 1'b1; tick(); ready = 1'b0;
        check("R3 stop exit to run", mode, 0);

        // Forced exits
        request(3'd3);
        freq = FW'(FMAX + 50);
        tick();
        check("R12 forced exit on frequency", mode, 5);
        check("R12 full regulation", loose, 0);
        freq = FW'(100);
        ready = 1'b1; tick(); ready = 1'b0;
        request(3'd4);
        check("R12 lp wait entered", mode, 4);
        clk_src = 2'd0; wake = 1'b1;
        tick();
        wake = 1'b0;
        check("R12 forced exit beats wake", mode, 5);
        clk_src = 2'd1;
        ready = 1'b1; tick(); ready = 1'b0;

        // Sticky error and the clear race
        clear_err();
        lvd_se = 1'b1;
        request(3'd3);
        check("R8 refused keeps run", mode, 0);
        check("R8 error set", err, 1);
        repeat (3) tick();
        check("R8 error sticky", err, 1);
        lvd_se = 1'b0;
        request(3'd3);
        check("R8 error survives accepted entry", err, 1);
        leave_lp("err");
        lvd_se = 1'b1;
        err_clr = 1'b1;
        request(3'd4);
        err_clr = 1'b0;
        check("R8 refusal wins over clear", err, 1);
        clear_err();
        check("R8 clear", err, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule